// File: doc/BRIEF.md
# Exception Entry and Status-Register Bank

This block owns the processor status word and five saved-status registers, one for each privileged mode that has one: supervisor, undefined, abort, IRQ and FIQ. Each cycle it may take one exception from a vector of request lines. When it takes one, it builds the new status word, copies the old word into the saved-status register of the target mode, and issues a one-cycle branch request. The branch request carries the vector address, the return-link value and the mode whose link register receives that value.

When no exception is taken, the status word can be written directly. The saved-status register of the current mode can also be written. A hold input freezes every state update. An active-low synchronous reset puts the block into the state that a reset exception produces, and it also clears the saved-status bank.

Top module: `trap_status_unit`

## Requirements
- R1: While `rstN` is low at a clock edge, the edge sets `psr` to 0x000000D3 and clears all five saved-status registers. After that edge `branchValid` is 1, `branchAddr` is the vector base, `linkValid` is 0 and `intAck` is 0.
- R2: Request bit positions in `excReq` are reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, IRQ 5 and FIQ 6. The target mode written to `psr[4:0]` and `linkMode` is as follows: reset and software interrupt go to supervisor 10011, undefined to 11011, both aborts to abort 10111, IRQ to 10010 and FIQ to 10001.
- R3: Every exception entry sets `psr[7]`, clears `psr[5]` and keeps `psr[31:8]`.
- R4: Reset and FIQ set `psr[6]`. Every other exception leaves `psr[6]` as it was.
- R5: `branchAddr` is the base plus the vector offset. The base is 0x00000000, or 0xFFFF0000 when `highVec` is 1. The offsets are reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18 and FIQ 0x1C.
- R6: Every exception except reset copies the status word held before entry into the saved-status register of its target mode. A reset request leaves the supervisor saved-status register unchanged. `savedOut` shows the saved-status register of the current mode, and shows 0 in a mode that has none.
- R7: `linkValue` is set as follows: `nextPc` for undefined and software interrupt, `faultPc`+4 for prefetch abort, `faultPc`+8 for data abort, and `nextPc`+4 for IRQ and FIQ. `linkValid` is 1 for every entry except reset.
- R8: `intAck` is 1 for exactly the cycle after an IRQ entry, and it stays 0 for every other exception kind.
- R9: When several requests are present together, only one is taken, in this order: reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R10: While `hold` is 1 and `rstN` is 1, no request is taken, `psr` and the bank do not change, and `branchValid` and `intAck` stay 0.
- R11: `psrWrEn` loads `psrWrData` into `psr` one edge later. An exception taken at the same edge wins, and the write is dropped.
- R12: `savedWrEn` loads `savedWrData` into the saved-status register of the current mode. The write is ignored in user mode (10000) and system mode (11111).
- R13: `branchValid` and `linkValid` are one-cycle pulses per taken request. They return to 0 at the next edge when no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset, treated as a reset exception |
| hold | input | 1 | Freezes all state updates |
| highVec | input | 1 | Selects the high vector base |
| excReq | input | 7 | Exception request lines |
| nextPc | input | 32 | Address of the next instruction |
| faultPc | input | 32 | Address of the aborted instruction |
| psrWrEn | input | 1 | Direct status-word write strobe |
| psrWrData | input | 32 | Direct status-word write data |
| savedWrEn | input | 1 | Current-mode saved-status write strobe |
| savedWrData | input | 32 | Saved-status write data |
| psr | output | 32 | Registered status word |
| savedOut | output | 32 | Saved-status register of the current mode |
| branchValid | output | 1 | Branch request pulse |
| branchAddr | output | 32 | Vector address |
| linkValid | output | 1 | Link write pulse |
| linkValue | output | 32 | Return-link value |
| linkMode | output | 5 | Mode whose link register takes `linkValue` |
| intAck | output | 1 | IRQ acknowledge pulse |

## Verification
Every result appears one register stage after the edge that samples a request or write. This covers `psr`, the bank seen through `savedOut`, and the branch, link and acknowledge outputs. The bench drives inputs just after a falling edge and lets one rising edge pass. It then reads all outputs at the following falling edge, well away from any active edge. The pulse and hold checks take one more idle edge and confirm that the outputs returned to 0 or stayed frozen.

// File: rtl/trap_status_pkg.sv
package trap_status_pkg;

  localparam int NUM_REQ   = 7;
  localparam int NUM_BANKS = 5;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  // request bit positions
  localparam int REQ_RESET = 0;
  localparam int REQ_UNDEF = 1;
  localparam int REQ_SWI   = 2;
  localparam int REQ_PABT  = 3;
  localparam int REQ_DABT  = 4;
  localparam int REQ_IRQ   = 5;
  localparam int REQ_FIQ   = 6;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  typedef enum logic [2:0] {
    EX_NONE, EX_RESET, EX_UNDEF, EX_SWI, EX_PABT, EX_DABT, EX_IRQ, EX_FIQ
  } excKind_e;

  typedef struct packed {
    logic              valid;
    logic [BANK_W-1:0] idx;
  } bankSel_t;

  typedef struct packed {
    logic              take;
    logic              hardReset;
    excKind_e          kind;
    logic [4:0]        mode;
    logic              setF;
    logic              saveOld;
    logic [BANK_W-1:0] bank;
    logic              linkEn;
    logic              irqAck;
    logic              psrWr;
    logic              savedWr;
    logic [BANK_W-1:0] savedBank;
  } trapStrobe_t;

  function automatic bankSel_t bankOf(input logic [4:0] m);
    bankSel_t s;
    s.valid = 1'b1;
    case (m)
      MODE_SVC: s.idx = BANK_W'(0);
      MODE_UND: s.idx = BANK_W'(1);
      MODE_ABT: s.idx = BANK_W'(2);
      MODE_IRQ: s.idx = BANK_W'(3);
      MODE_FIQ: s.idx = BANK_W'(4);
      default: begin
        s.valid = 1'b0;
        s.idx   = '0;
      end
    endcase
    return s;
  endfunction

  function automatic logic [7:0] vecOffset(input excKind_e k);
    case (k)
      EX_UNDEF: return 8'h04;
      EX_SWI:   return 8'h08;
      EX_PABT:  return 8'h0C;
      EX_DABT:  return 8'h10;
      EX_IRQ:   return 8'h18;
      EX_FIQ:   return 8'h1C;
      default:  return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/trap_status_ctrl.sv
module trap_status_ctrl
  import trap_status_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hold,
  input  logic [NUM_REQ-1:0] excReq,
  input  logic               psrWrEn,
  input  logic               savedWrEn,
  input  logic [4:0]         curMode,
  output trapStrobe_t        strobe
);

  // fixed priority, highest first
  localparam int PRIO [NUM_REQ] = '{REQ_RESET, REQ_DABT, REQ_FIQ, REQ_IRQ,
                                    REQ_PABT, REQ_UNDEF, REQ_SWI};

  logic [NUM_REQ-1:0] grant;
  excKind_e           kind;
  bankSel_t           tgtSel, curSel;
  logic               live;

  always_comb begin
    logic found;
    grant = '0;
    found = 1'b0;
    for (int p = 0; p < NUM_REQ; p++) begin
      if (excReq[PRIO[p]] && !found) begin
        grant[PRIO[p]] = 1'b1;
        found = 1'b1;
      end
    end
    if (!rstN) grant = NUM_REQ'(1) << REQ_RESET;
  end

  always_comb begin
    kind = EX_NONE;
    if      (grant[REQ_RESET]) kind = EX_RESET;
    else if (grant[REQ_DABT])  kind = EX_DABT;
    else if (grant[REQ_FIQ])   kind = EX_FIQ;
    else if (grant[REQ_IRQ])   kind = EX_IRQ;
    else if (grant[REQ_PABT])  kind = EX_PABT;
    else if (grant[REQ_UNDEF]) kind = EX_UNDEF;
    else if (grant[REQ_SWI])   kind = EX_SWI;
  end

  assign live = rstN && !hold;

  always_comb begin
    strobe = '0;
    strobe.hardReset = !rstN;
    strobe.take      = !rstN || (live && (kind != EX_NONE));
    strobe.kind      = kind;
    case (kind)
      EX_UNDEF:       strobe.mode = MODE_UND;
      EX_PABT,EX_DABT: strobe.mode = MODE_ABT;
      EX_IRQ:         strobe.mode = MODE_IRQ;
      EX_FIQ:         strobe.mode = MODE_FIQ;
      default:        strobe.mode = MODE_SVC;
    endcase
    tgtSel           = bankOf(strobe.mode);
    curSel           = bankOf(curMode);
    strobe.setF      = (kind == EX_RESET) || (kind == EX_FIQ);
    strobe.saveOld   = strobe.take && (kind != EX_RESET) && tgtSel.valid;
    strobe.bank      = tgtSel.idx;
    strobe.linkEn    = strobe.take && (kind != EX_RESET);
    strobe.irqAck    = strobe.take && (kind == EX_IRQ);
    strobe.psrWr     = live && psrWrEn && !strobe.take;
    strobe.savedWr   = live && savedWrEn && !strobe.take && curSel.valid;
    strobe.savedBank = curSel.idx;
  end

  // R9: at most one request granted
  p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

endmodule

// File: rtl/trap_status_dp.sv
module trap_status_dp
  import trap_status_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter logic [DATA_W-1:0] HIGH_BASE = 32'hFFFF0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hold,
  input  logic              highVec,
  input  logic [DATA_W-1:0] nextPc,
  input  logic [DATA_W-1:0] faultPc,
  input  logic [DATA_W-1:0] psrWrData,
  input  logic [DATA_W-1:0] savedWrData,
  input  trapStrobe_t       strobe,
  output logic [DATA_W-1:0] psr,
  output logic [DATA_W-1:0] savedOut,
  output logic              branchValid,
  output logic [DATA_W-1:0] branchAddr,
  output logic              linkValid,
  output logic [DATA_W-1:0] linkValue,
  output logic [4:0]        linkMode,
  output logic              intAck
);

  logic [DATA_W-1:0] psrQ;
  logic [DATA_W-1:0] bankQ [NUM_BANKS];
  logic [DATA_W-1:0] newPsr, basePsr, vecAddr, linkNext;
  bankSel_t          curSel;

  always_comb begin
    basePsr   = strobe.hardReset ? '0 : psrQ;
    newPsr    = basePsr;
    newPsr[7] = 1'b1;
    newPsr[6] = strobe.setF | basePsr[6];
    newPsr[5] = 1'b0;
    newPsr[4:0] = strobe.mode;
  end

  assign vecAddr = (highVec ? HIGH_BASE : '0) | DATA_W'(vecOffset(strobe.kind));

  always_comb begin
    case (strobe.kind)
      EX_PABT:       linkNext = faultPc + DATA_W'(4);
      EX_DABT:       linkNext = faultPc + DATA_W'(8);
      EX_IRQ,EX_FIQ: linkNext = nextPc + DATA_W'(4);
      default:       linkNext = nextPc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.take)       psrQ <= newPsr;
    else if (strobe.psrWr) psrQ <= psrWrData;
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strobe.hardReset)
        bankQ[b] <= '0;
      else if (strobe.saveOld && strobe.bank == BANK_W'(b))
        bankQ[b] <= psrQ;
      else if (strobe.savedWr && strobe.savedBank == BANK_W'(b))
        bankQ[b] <= savedWrData;
    end
  end

  always_ff @(posedge clk) begin
    branchValid <= strobe.take;
    linkValid   <= strobe.linkEn;
    intAck      <= strobe.irqAck;
    if (strobe.take) branchAddr <= vecAddr;
    if (strobe.linkEn) begin
      linkValue <= linkNext;
      linkMode  <= strobe.mode;
    end
  end

  assign curSel   = bankOf(psrQ[4:0]);
  assign savedOut = curSel.valid ? bankQ[curSel.idx] : '0;
  assign psr      = psrQ;

  // R3: every entry leaves interrupts masked and the state bit clear
  p_entry_masks_r3: assert property (@(posedge clk) disable iff (!rstN)
    branchValid |-> (psr[7] && !psr[5]));

  // R10: a held cycle leaves the status word untouched
  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hold && rstN) |=> $stable(psr));

  // R8: acknowledge only alongside an IRQ entry
  p_ack_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    intAck |-> (branchValid && linkMode == MODE_IRQ));

endmodule

// File: rtl/trap_status_unit.sv
module trap_status_unit
  import trap_status_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] HIGH_BASE = 32'hFFFF0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hold,
  input  logic               highVec,
  input  logic [NUM_REQ-1:0] excReq,
  input  logic [DATA_W-1:0]  nextPc,
  input  logic [DATA_W-1:0]  faultPc,
  input  logic               psrWrEn,
  input  logic [DATA_W-1:0]  psrWrData,
  input  logic               savedWrEn,
  input  logic [DATA_W-1:0]  savedWrData,
  output logic [DATA_W-1:0]  psr,
  output logic [DATA_W-1:0]  savedOut,
  output logic               branchValid,
  output logic [DATA_W-1:0]  branchAddr,
  output logic               linkValid,
  output logic [DATA_W-1:0]  linkValue,
  output logic [4:0]         linkMode,
  output logic               intAck
);

  trapStrobe_t strobe;

  trap_status_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .hold      (hold),
    .excReq    (excReq),
    .psrWrEn   (psrWrEn),
    .savedWrEn (savedWrEn),
    .curMode   (psr[4:0]),
    .strobe    (strobe)
  );

  trap_status_dp #(.DATA_W(DATA_W), .HIGH_BASE(HIGH_BASE)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .hold        (hold),
    .highVec     (highVec),
    .nextPc      (nextPc),
    .faultPc     (faultPc),
    .psrWrData   (psrWrData),
    .savedWrData (savedWrData),
    .strobe      (strobe),
    .psr         (psr),
    .savedOut    (savedOut),
    .branchValid (branchValid),
    .branchAddr  (branchAddr),
    .linkValid   (linkValid),
    .linkValue   (linkValue),
    .linkMode    (linkMode),
    .intAck      (intAck)
  );

endmodule

// File: tb/trap_status_unit_test.sv
`timescale 1ns/100ps
module trap_status_unit_test;

  localparam logic [6:0] RQ_RESET = 7'h01, RQ_UNDEF = 7'h02, RQ_SWI = 7'h04,
                         RQ_PABT = 7'h08, RQ_DABT = 7'h10, RQ_IRQ = 7'h20,
                         RQ_FIQ = 7'h40;

  logic        clk = 1'b0;
  logic        rstN, hold, highVec, psrWrEn, savedWrEn;
  logic [6:0]  excReq;
  logic [31:0] nextPc, faultPc, psrWrData, savedWrData;
  logic [31:0] psr, savedOut, branchAddr, linkValue;
  logic        branchValid, linkValid, intAck;
  logic [4:0]  linkMode;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  trap_status_unit uut (
    .clk(clk), .rstN(rstN), .hold(hold), .highVec(highVec), .excReq(excReq),
    .nextPc(nextPc), .faultPc(faultPc), .psrWrEn(psrWrEn), .psrWrData(psrWrData),
    .savedWrEn(savedWrEn), .savedWrData(savedWrData), .psr(psr), .savedOut(savedOut),
    .branchValid(branchValid), .branchAddr(branchAddr), .linkValid(linkValid),
    .linkValue(linkValue), .linkMode(linkMode), .intAck(intAck)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setPsr(input logic [31:0] v);
    psrWrEn = 1'b1; psrWrData = v;
    tick();
    psrWrEn = 1'b0;
  endtask

  task automatic fire(input logic [6:0] req, input logic [31:0] np,
                      input logic [31:0] fp, input logic hv);
    excReq = req; nextPc = np; faultPc = fp; highVec = hv;
    tick();
    excReq = '0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    tick();
    chk("R1", "psr", psr, 32'h000000D3);
    chk("R1", "branchValid", {31'd0, branchValid}, 32'd1);
    chk("R1", "branchAddr", branchAddr, 32'h0);
    chk("R1", "linkValid", {31'd0, linkValid}, 32'd0);
    chk("R1", "savedOut", savedOut, 32'h0);
    chk("R1", "intAck", {31'd0, intAck}, 32'd0);
    rstN = 1'b1;
    tick();
    chk("R13", "branchValid idle", {31'd0, branchValid}, 32'd0);
  endtask

  task automatic testPsrWrite();
    setPsr(32'h60000010);
    chk("R11", "psr write", psr, 32'h60000010);
    chk("R6", "savedOut user", savedOut, 32'h0);
  endtask

  task automatic testSavedWrite();
    savedWrEn = 1'b1; savedWrData = 32'h12345678;
    tick();
    setPsr(32'h0000001F);
    savedWrEn = 1'b1; savedWrData = 32'h87654321;
    tick();
    savedWrEn = 1'b0;
    setPsr(32'h00000013);
    chk("R12", "user/system write ignored", savedOut, 32'h0);
    savedWrEn = 1'b1; savedWrData = 32'hCAFE0011;
    tick();
    savedWrEn = 1'b0;
    chk("R12", "svc saved write", savedOut, 32'hCAFE0011);
  endtask

  task automatic testSwi();
    setPsr(32'hA0000050);
    fire(RQ_SWI, 32'h1000, 32'h0, 1'b0);
    chk("R2", "swi psr", psr, 32'hA00000D3);
    chk("R5", "swi vector", branchAddr, 32'h08);
    chk("R7", "swi link", linkValue, 32'h1000);
    chk("R2", "swi linkMode", {27'd0, linkMode}, 32'h13);
    chk("R6", "swi saved", savedOut, 32'hA0000050);
    chk("R8", "swi no ack", {31'd0, intAck}, 32'd0);
    chk("R7", "swi linkValid", {31'd0, linkValid}, 32'd1);
    tick();
    chk("R13", "branch pulse ends", {31'd0, branchValid}, 32'd0);
    chk("R13", "link pulse ends", {31'd0, linkValid}, 32'd0);
  endtask

  task automatic testUndef();
    setPsr(32'h00000010);
    fire(RQ_UNDEF, 32'h2000, 32'h0, 1'b1);
    chk("R4", "undef psr", psr, 32'h0000009B);
    chk("R5", "undef high vector", branchAddr, 32'hFFFF0004);
    chk("R7", "undef link", linkValue, 32'h2000);
    chk("R6", "undef saved", savedOut, 32'h00000010);
  endtask

  task automatic testPabt();
    setPsr(32'h20000030);
    fire(RQ_PABT, 32'h0, 32'h3000, 1'b0);
    chk("R3", "pabt psr", psr, 32'h20000097);
    chk("R5", "pabt vector", branchAddr, 32'h0C);
    chk("R7", "pabt link", linkValue, 32'h3004);
    chk("R2", "pabt linkMode", {27'd0, linkMode}, 32'h17);
    chk("R6", "pabt saved", savedOut, 32'h20000030);
  endtask

  task automatic testDabt();
    setPsr(32'h00000050);
    fire(RQ_DABT, 32'h0, 32'h4000, 1'b1);
    chk("R4", "dabt keeps F", psr, 32'h000000D7);
    chk("R5", "dabt vector", branchAddr, 32'hFFFF0010);
    chk("R7", "dabt link", linkValue, 32'h4008);
    chk("R6", "dabt saved", savedOut, 32'h00000050);
  endtask

  task automatic testIrq();
    setPsr(32'h00000010);
    fire(RQ_IRQ, 32'h5000, 32'h0, 1'b0);
    chk("R2", "irq psr", psr, 32'h00000092);
    chk("R5", "irq vector", branchAddr, 32'h18);
    chk("R7", "irq link", linkValue, 32'h5004);
    chk("R8", "irq ack", {31'd0, intAck}, 32'd1);
    tick();
    chk("R8", "irq ack ends", {31'd0, intAck}, 32'd0);
  endtask

  task automatic testFiq();
    setPsr(32'h00000010);
    fire(RQ_FIQ, 32'h6000, 32'h0, 1'b0);
    chk("R4", "fiq psr", psr, 32'h000000D1);
    chk("R5", "fiq vector", branchAddr, 32'h1C);
    chk("R7", "fiq link", linkValue, 32'h6004);
    chk("R6", "fiq saved", savedOut, 32'h00000010);
    chk("R8", "fiq no ack", {31'd0, intAck}, 32'd0);
  endtask

  task automatic testPriority();
    setPsr(32'h00000010);
    fire(RQ_IRQ | RQ_FIQ | RQ_UNDEF, 32'h100, 32'h700, 1'b0);
    chk("R9", "fiq over irq", {27'd0, psr[4:0]}, 32'h11);
    chk("R9", "fiq vector", branchAddr, 32'h1C);
    setPsr(32'h00000010);
    fire(RQ_DABT | RQ_FIQ | RQ_PABT, 32'h100, 32'h700, 1'b0);
    chk("R9", "dabt over fiq", {27'd0, psr[4:0]}, 32'h17);
    chk("R9", "dabt link", linkValue, 32'h708);
    setPsr(32'h00000010);
    fire(RQ_UNDEF | RQ_SWI, 32'h100, 32'h700, 1'b0);
    chk("R9", "undef over swi", branchAddr, 32'h04);
    setPsr(32'hF0000010);
    fire(RQ_RESET | RQ_IRQ | RQ_DABT, 32'h100, 32'h700, 1'b1);
    chk("R9", "reset wins psr", psr, 32'hF00000D3);
    chk("R5", "reset high vector", branchAddr, 32'hFFFF0000);
    chk("R7", "reset no link", {31'd0, linkValid}, 32'd0);
    chk("R6", "reset keeps svc saved", savedOut, 32'hA0000050);
  endtask

  task automatic testHold();
    setPsr(32'h00000010);
    hold = 1'b1; excReq = RQ_IRQ;
    psrWrEn = 1'b1; psrWrData = 32'h0000001F;
    tick();
    chk("R10", "psr frozen", psr, 32'h00000010);
    chk("R10", "no branch", {31'd0, branchValid}, 32'd0);
    chk("R10", "no ack", {31'd0, intAck}, 32'd0);
    hold = 1'b0; excReq = '0; psrWrEn = 1'b0;
  endtask

  task automatic testExcBeatsWrite();
    setPsr(32'h00000010);
    excReq = RQ_SWI; psrWrEn = 1'b1; psrWrData = 32'h0000001F;
    tick();
    excReq = '0; psrWrEn = 1'b0;
    chk("R11", "exception beats write", psr, 32'h00000093);
  endtask

  initial begin
    rstN = 1'b0; hold = 1'b0; highVec = 1'b0; excReq = '0;
    nextPc = '0; faultPc = '0; psrWrEn = 1'b0; psrWrData = '0;
    savedWrEn = 1'b0; savedWrData = '0;
    testReset();
    testPsrWrite();
    testSavedWrite();
    testSwi();
    testUndef();
    testPabt();
    testDabt();
    testIrq();
    testFiq();
    testPriority();
    testHold();
    testExcBeatsWrite();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule